// File: doc/BRIEF.md
# SR-IOV Routing ID Decoder

This block sits on the configuration request path of a PCIe endpoint that exposes one physical function (PF) and a set of virtual functions (VFs). A configuration request carries an 8-bit device/function number (devfn). The block decides whether that number addresses the PF, addresses one of the enabled VFs, or misses. When it addresses a VF, the block also reports that VF's index. VF n sits at devfn = PF devfn + first-VF offset + n × VF stride. The PF devfn, offset, stride, total VF count, ARI capability and PF vendor ID are elaboration parameters.

The run-time inputs come from the capability registers: the VF-enable bit and the programmed VF count. They are sampled together with the request devfn when the request is accepted. The block subtracts the base of the progression and then runs a bit-serial restoring divider by the stride. The remainder shows whether the devfn falls exactly on the progression, and the quotient is the VF index. The response appears after a fixed number of cycles together with a one-cycle valid strobe. It also carries the vendor ID value that a read of that function returns.

A separate static output flags a parameter set that could never be legal:
- the last VF falls outside the 256-entry devfn space;
- without ARI, the last VF leaves the PF's device (slot) number;
- the stride is zero while more than one VF exists.

Top module: `sriov_rid_decoder`

## Requirements
- R1: A request whose devfn equals the PF devfn always reports a PF hit (`rsp_hit`=1, `rsp_is_vf`=0), whatever the VF-enable bit or VF count. Its vendor ID is the PF vendor ID parameter.
- R2: A request at devfn PF + offset + n × stride reports a VF hit with `rsp_vf_index`=n, provided the configuration is legal, VF enable is 1, n < total VFs and n < the programmed VF count.
- R3: With VF enable 0, no request reports a VF hit.
- R4: A devfn on the progression whose index n is at or above the programmed VF count, or at or above the total VF count, misses (`rsp_hit`=0).
- R5: A devfn below the progression base, or one whose distance from the base is not an exact multiple of the stride, misses. With a stride of 0, only the base itself is VF 0.
- R6: For a VF hit or a miss, `rsp_vendor_id` is 16'hFFFF. On a miss, and on a PF hit, `rsp_vf_index` is 0.
- R7: `cfg_bad` is 1 exactly when total VFs > 0 and one of these holds: the last VF devfn ≥ 256; ARI is off and devfn bits [7:3] of the last VF differ from those of the PF; the stride is 0 and total VFs > 1. While `cfg_bad` is 1, no VF hit is reported.
- R8: After reset, `req_ready`=1 and `rsp_valid`=0. A request accepted on a clock edge (`req_valid` and `req_ready` both 1) produces `rsp_valid`=1 for exactly one cycle, starting at the 9th edge after acceptance. `req_ready` is 0 from acceptance until that response edge, and is 1 again in the response cycle.
- R9: The devfn, VF enable and VF count are sampled only at acceptance. Changes while busy, and requests presented while `req_ready`=0, do not affect the response in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_devfn | input | 8 | Requested device/function number |
| vf_enable | input | 1 | VF enable bit from the capability control register |
| num_vfs | input | 16 | Programmed VF count |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Request addresses the PF or an enabled VF |
| rsp_is_vf | output | 1 | Hit is on a VF |
| rsp_vf_index | output | 8 | Index of the addressed VF |
| rsp_vendor_id | output | 16 | Vendor ID value a read of this function returns |
| cfg_bad | output | 1 | Static flag for an illegal offset/stride/count set |

## Verification
The bench predicts each response from the requirement arithmetic: it walks the progression index by index and does no division. Each response is due exactly nine clock edges after the accepting edge. The reference model keeps a countdown that starts at the accepting edge and raises the expected strobe and ready on the ninth edge. Ready, valid and, in a response cycle, all response fields are compared at every falling edge, away from the edges where the design updates. Because the inputs are scrambled after acceptance and requests are held during busy periods, any late sampling shows up as a field mismatch in that response cycle. `cfg_bad` is static and is compared once after reset.

// File: rtl/sriov_rid_pkg.sv
package sriov_rid_pkg;
    localparam int DEVFN_W = 8;
    localparam int ID_W    = 16;
    localparam int NUM_W   = 16;

    typedef struct packed {
        logic               busy;
        logic               pf_match;
        logic               in_range;
        logic               vf_en;
        logic [NUM_W-1:0]   num;
        logic               rsp_valid;
        logic               rsp_hit;
        logic               rsp_is_vf;
        logic [DEVFN_W-1:0] rsp_idx;
        logic [ID_W-1:0]    rsp_vid;
    } dec_state_t;
endpackage

// File: rtl/sriov_rid_cfg_chk.sv
module sriov_rid_cfg_chk #(
    parameter int PF_DEVFN  = 16,
    parameter int VF_OFFSET = 1,
    parameter int VF_STRIDE = 1,
    parameter int TOTAL_VFS = 7,
    parameter bit ARI_EN    = 1'b0
) (
    output logic bad
);
    import sriov_rid_pkg::*;

    localparam int SPACE    = 1 << DEVFN_W;
    localparam int LAST     = PF_DEVFN + VF_OFFSET + VF_STRIDE * (TOTAL_VFS - 1);
    localparam bit OVERFLOW = LAST >= SPACE;
    localparam bit SLOT_BAD = !ARI_EN && ((LAST >> 3) != (PF_DEVFN >> 3));
    localparam bit ZERO_BAD = (VF_STRIDE == 0) && (TOTAL_VFS > 1);
    localparam bit IS_BAD   = (TOTAL_VFS > 0) && (OVERFLOW || SLOT_BAD || ZERO_BAD);

    assign bad = IS_BAD;
endmodule

// File: rtl/sriov_rid_divider.sv
module sriov_rid_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     dvd;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     orig;
        logic [W-1:0]     dsr;
        logic             done;
    } div_state_t;

    div_state_t q, d;
    logic [W:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        trial   = {q.rem, q.dvd[W-1]};
        if (start) begin
            d.cnt  = CNT_W'(W);
            d.dvd  = dividend;
            d.orig = dividend;
            d.dsr  = divisor;
            d.rem  = '0;
            d.quo  = '0;
        end else if (q.cnt != '0) begin
            d.dvd = {q.dvd[W-2:0], 1'b0};
            if (trial >= {1'b0, q.dsr}) begin
                d.rem = W'(trial - {1'b0, q.dsr});
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = trial[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign quotient  = q.quo;
    assign remainder = q.rem;

    // One division in flight at a time (R9)
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.cnt == '0));

    // Completion strobe lasts one cycle (R8)
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // Quotient and remainder reconstruct the sampled distance (R2)
    assert_div_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.dsr != '0) |->
            ((2*W)'(q.quo) * (2*W)'(q.dsr) + (2*W)'(q.rem) == (2*W)'(q.orig))
            && (q.rem < q.dsr));
endmodule

// File: rtl/sriov_rid_decoder.sv
module sriov_rid_decoder #(
    parameter int          PF_DEVFN     = 16,
    parameter int          VF_OFFSET    = 1,
    parameter int          VF_STRIDE    = 1,
    parameter int          TOTAL_VFS    = 7,
    parameter bit          ARI_EN       = 1'b0,
    parameter logic [15:0] PF_VENDOR_ID = 16'hA5C3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_devfn,
    input  logic        vf_enable,
    input  logic [15:0] num_vfs,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_is_vf,
    output logic [7:0]  rsp_vf_index,
    output logic [15:0] rsp_vendor_id,
    output logic        cfg_bad
);
    import sriov_rid_pkg::*;

    localparam int SPACE      = 1 << DEVFN_W;
    localparam int BASE       = PF_DEVFN + VF_OFFSET;
    localparam int STRIDE_EFF = (VF_STRIDE >= SPACE) ? 0 : VF_STRIDE;
    localparam logic [DEVFN_W-1:0] BASE_T   = DEVFN_W'(BASE % SPACE);
    localparam logic [DEVFN_W-1:0] STRIDE_T = DEVFN_W'(STRIDE_EFF);
    localparam logic [DEVFN_W-1:0] PF_T     = DEVFN_W'(PF_DEVFN);

    dec_state_t q, d;

    logic               accept;
    logic               div_done;
    logic [DEVFN_W-1:0] div_quo;
    logic [DEVFN_W-1:0] div_rem;
    logic [DEVFN_W-1:0] delta;
    logic [DEVFN_W-1:0] idx;
    logic               exact;
    logic               vf_hit;

    sriov_rid_cfg_chk #(
        .PF_DEVFN (PF_DEVFN),
        .VF_OFFSET(VF_OFFSET),
        .VF_STRIDE(VF_STRIDE),
        .TOTAL_VFS(TOTAL_VFS),
        .ARI_EN   (ARI_EN)
    ) u_cfg_chk (
        .bad(cfg_bad)
    );

    assign accept = req_valid && !q.busy;
    assign delta  = req_devfn - BASE_T;

    sriov_rid_divider #(
        .W(DEVFN_W)
    ) u_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .dividend (delta),
        .divisor  (STRIDE_T),
        .done     (div_done),
        .quotient (div_quo),
        .remainder(div_rem)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        idx         = (STRIDE_EFF == 0) ? '0 : div_quo;
        exact       = (div_rem == '0);
        vf_hit      = !q.pf_match && q.in_range && exact && !cfg_bad && q.vf_en
                      && (int'(idx) < TOTAL_VFS) && ({8'd0, idx} < q.num);
        if (accept) begin
            d.busy     = 1'b1;
            d.pf_match = (req_devfn == PF_T);
            d.in_range = (BASE < SPACE) && (int'(req_devfn) >= BASE);
            d.vf_en    = vf_enable;
            d.num      = num_vfs;
        end else if (div_done) begin
            d.busy      = 1'b0;
            d.rsp_valid = 1'b1;
            d.rsp_hit   = q.pf_match || vf_hit;
            d.rsp_is_vf = vf_hit;
            d.rsp_idx   = vf_hit ? idx : '0;
            d.rsp_vid   = q.pf_match ? PF_VENDOR_ID : 16'hFFFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = !q.busy;
    assign rsp_valid     = q.rsp_valid;
    assign rsp_hit       = q.rsp_hit;
    assign rsp_is_vf     = q.rsp_is_vf;
    assign rsp_vf_index  = q.rsp_idx;
    assign rsp_vendor_id = q.rsp_vid;

    // PF devfn always wins (R1)
    assert_pf_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && q.pf_match) |-> (q.rsp_hit && !q.rsp_is_vf));

    // No VF hit without the sampled enable (R3)
    assert_vf_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && q.rsp_is_vf) |-> q.vf_en);

    // VF index stays below the sampled count (R4)
    assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rsp_valid && q.rsp_is_vf) |-> ({8'd0, q.rsp_idx} < q.num));

    // Illegal configuration never yields a VF (R7)
    assert_bad_no_vf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bad && q.rsp_valid) |-> !q.rsp_is_vf);

    // Ready returns in the response cycle and the response lasts one cycle (R8)
    assert_rsp_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.rsp_valid |-> (req_ready && $past(!req_ready)));
endmodule

// File: tb/sriov_rid_decoder_bench.sv
module sriov_rid_decoder_bench;
    localparam int NI  = 6;
    localparam int LAT = 9;
    localparam int P_PF  [NI] = '{16, 32, 16, 64, 128, 72};
    localparam int P_OFF [NI] = '{1, 4, 1, 1, 16, 2};
    localparam int P_STR [NI] = '{1, 3, 1, 0, 8, 0};
    localparam int P_TOT [NI] = '{7, 20, 10, 3, 20, 1};
    localparam bit P_ARI [NI] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [15:0] VID = 16'hA5C3;

    typedef struct packed {
        logic        hit;
        logic        isvf;
        logic [7:0]  idx;
        logic [15:0] vid;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_devfn = '0;
    logic        vf_enable = 1'b0;
    logic [15:0] num_vfs = '0;

    logic        rdy [NI];
    logic        vld [NI];
    logic        hit [NI];
    logic        isvf[NI];
    logic [7:0]  idx [NI];
    logic [15:0] vid [NI];
    logic        bad [NI];

    int tests = 0;
    int fails = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : g_dut
        sriov_rid_decoder #(
            .PF_DEVFN (P_PF[g]),
            .VF_OFFSET(P_OFF[g]),
            .VF_STRIDE(P_STR[g]),
            .TOTAL_VFS(P_TOT[g]),
            .ARI_EN   (P_ARI[g]),
            .PF_VENDOR_ID(VID)
        ) u_sriov_rid_decoder (
            .clk(clk), .rst_n(rst_n),
            .req_valid(req_valid), .req_ready(rdy[g]),
            .req_devfn(req_devfn), .vf_enable(vf_enable), .num_vfs(num_vfs),
            .rsp_valid(vld[g]), .rsp_hit(hit[g]), .rsp_is_vf(isvf[g]),
            .rsp_vf_index(idx[g]), .rsp_vendor_id(vid[g]), .cfg_bad(bad[g])
        );
    end

    function automatic bit exp_bad(int g);
        int last;
        if (P_TOT[g] == 0) return 1'b0;
        last = P_PF[g] + P_OFF[g] + P_STR[g] * (P_TOT[g] - 1);
        if (last >= 256) return 1'b1;
        if (!P_ARI[g] && (last / 8) != (P_PF[g] / 8)) return 1'b1;
        if (P_STR[g] == 0 && P_TOT[g] > 1) return 1'b1;
        return 1'b0;
    endfunction

    function automatic res_t model(int g, int req, bit en, int num, output string tag);
        res_t r;
        int found;
        r.hit = 0; r.isvf = 0; r.idx = 0; r.vid = 16'hFFFF;
        found = -1;
        for (int n = 0; n < P_TOT[g]; n++) begin
            if (found < 0 && P_PF[g] + P_OFF[g] + n * P_STR[g] == req) found = n;
        end
        tag = "R5";
        if (req == P_PF[g]) begin
            r.hit = 1; r.vid = VID; tag = "R1";
        end else if (found >= 0) begin
            if (exp_bad(g)) tag = "R7";
            else if (!en) tag = "R3";
            else if (found >= num) tag = "R4";
            else begin
                r.hit = 1; r.isvf = 1; r.idx = 8'(found); tag = "R2";
            end
        end
        return r;
    endfunction

    // Reference timing model: countdown from the accepting edge
    int   cd = 0;
    logic e_rdy = 1'b1;
    logic e_vld = 1'b0;
    res_t e_res[NI];
    string e_tag[NI];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cd <= 0; e_rdy <= 1'b1; e_vld <= 1'b0;
        end else begin
            e_vld <= 1'b0;
            if (cd == 1) begin e_vld <= 1'b1; e_rdy <= 1'b1; end
            if (cd > 0) cd <= cd - 1;
            else if (req_valid && e_rdy) begin
                cd <= LAT; e_rdy <= 1'b0;
                for (int g = 0; g < NI; g++) begin
                    string t;
                    e_res[g] = model(g, int'(req_devfn), vf_enable, int'(num_vfs), t);
                    e_tag[g] = t;
                end
            end
        end
    end

    task automatic check(bit ok, string req, int g, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s inst%0d %s: actual=%0h expected=%0h", req, g, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            for (int g = 0; g < NI; g++) begin
                check(rdy[g] == e_rdy, "R8", g, "ready", int'(rdy[g]), int'(e_rdy));
                check(vld[g] == e_vld, "R8", g, "valid", int'(vld[g]), int'(e_vld));
                if (e_vld && vld[g]) begin
                    check(hit[g] == e_res[g].hit, e_tag[g], g, "hit", int'(hit[g]), int'(e_res[g].hit));
                    check(isvf[g] == e_res[g].isvf, e_tag[g], g, "is_vf", int'(isvf[g]), int'(e_res[g].isvf));
                    check(idx[g] == e_res[g].idx, e_tag[g], g, "index", int'(idx[g]), int'(e_res[g].idx));
                    check(vid[g] == e_res[g].vid, "R6", g, "vendor", int'(vid[g]), int'(e_res[g].vid));
                end
            end
        end
    end

    // One request; inputs scrambled right after acceptance (R9)
    task automatic send(int dv, bit en, int num);
        @(negedge clk);
        while (!rdy[0]) @(negedge clk);
        req_valid = 1'b1; req_devfn = 8'(dv); vf_enable = en; num_vfs = 16'(num);
        @(negedge clk);
        req_valid = 1'b0; req_devfn = req_devfn ^ 8'h5A; vf_enable = ~en; num_vfs = num_vfs ^ 16'h0005;
        while (!vld[0]) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            check(rdy[g] == 1'b1 && vld[g] == 1'b0, "R8", g, "reset state", int'({rdy[g], vld[g]}), 2);
            check(bad[g] == exp_bad(g), "R7", g, "cfg_bad", int'(bad[g]), int'(exp_bad(g)));
        end
        // R2 R5 full sweep, all VFs enabled
        for (int v = 0; v < 256; v++) send(v, 1'b1, 20);
        // R3 enable clear
        for (int v = 0; v < 128; v++) send(v, 1'b0, 20);
        // R4 partial count
        for (int v = 0; v < 128; v++) send(v, 1'b1, 2);
        // R1 PF with VFs off and count zero
        send(16, 1'b0, 0); send(32, 1'b0, 0); send(128, 1'b1, 0);
        // R9 request held through busy with devfn changing every cycle
        @(negedge clk);
        while (!rdy[0]) @(negedge clk);
        for (int k = 0; k < 80; k++) begin
            req_valid = 1'b1; req_devfn = 8'($urandom_range(0, 95));
            vf_enable = 1'($urandom_range(0, 1)); num_vfs = 16'($urandom_range(0, 21));
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        done_run = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule